// File: doc/BRIEF.md
# Task-File Window Decoder With Byte Packing

This block sits between a host port, used either as common memory or as I/O space, and a 16-bit ATA-style task-file register set. Each host access is checked against an address window that depends on a two-bit addressing mode, and a hit is turned into a four-bit register offset. The offset then goes to one of three places: the task-file register port, the block's own device-control register, or a read value that the block builds itself.

Eight-bit hosts reach the 16-bit data register through a byte data offset. A single cycle flag joins two byte accesses into one word transfer on the task-file side. On reads, the first byte access fetches the word and the second returns the stored upper byte. On writes, the first byte is held and the second completes the word. The block also builds the device-address read value from the drive-select nibble. When a power-down flag is set, it raises a wake strobe on register writes that pass through to the task file.

The task-file strobes are combinational, in the same cycle as the host access. The host read data is registered.

Top module: `tfw_decoder_top`

## Requirements
- R1: Mode 0 (memory) accepts an address only when the bits above bit 9 equal 1, that is 0x400–0x7FF for an 11-bit address. The offset is address bits 3:0.
- R2: Mode 1 (contiguous I/O) accepts every address, and the offset is address bits 3:0.
- R3: Mode 2 (primary) accepts the blocks 0x1F0–0x1FF and 0x3F0–0x3FF. Mode 3 (secondary) accepts 0x170–0x17F and 0x370–0x37F. In the lower block the offset is address bits 3:0. In the upper block it is 8 plus address bits 2:0, so x6 maps to offset 0xE and x7 to 0xF.
- R4: An access outside the window raises no task-file strobe and no wake. It does not change the cycle flag, the byte latch or the control register. A read outside the window returns 0x0000.
- R5: Offset 0x0 is the word data port. It makes one 16-bit task-file transfer at task-file address 0, in the same cycle, with the full host word.
- R6: A read at offset 0x8 when the cycle flag is clear fetches a word from task-file address 0 and returns {0x00, low byte}. When the flag is set, the read makes no task-file access and returns {0x00, high byte of the stored word}.
- R7: A write at offset 0x8 when the cycle flag is clear only stores host bits 7:0. When the flag is set, it writes {host bits 7:0, stored byte} to task-file address 0.
- R8: Every in-window access at offset 0x8, read or write, toggles the cycle flag. Reset clears the flag, so the first byte access after reset is always a first-byte access.
- R9: Offset 0xD reaches task-file address 1 for both reads (error) and writes (features).
- R10: A read at offset 0xE is an alternate-status read: task-file address 7 with the alternate flag raised. A write at offset 0xE makes no task-file access and loads host bits 7:0 into the device-control output (reset value 0x00) on the next edge. In the cycle after the write, an interrupt re-evaluation pulse is raised, plus a software-reset pulse if bit 2 of the written value is set.
- R11: A read at offset 0xF returns 0x00C2 ORed with the inverted drive-select nibble shifted left by two, that is 0xC2 | (~sel << 2) & 0x3C. A write at offset 0xF is ignored.
- R12: Offsets 0x1–0x7 and 0x9–0xC pass through to task-file address offset[2:0]. A write there while power-down is set raises the wake strobe in the same cycle as the task-file write. No other access raises wake.
- R13: Host read data appears on the clock edge after the read strobe and holds until the next read. Its reset value is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Addressing mode: 0 memory, 1 contiguous I/O, 2 primary, 3 secondary |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| head_sel | input | 4 | Drive-select nibble of the active drive |
| pwr_down | input | 1 | Power-down flag held by the configuration logic |
| wake | output | 1 | Clear power-down and set card-ready |
| tf_cs | output | 1 | Task-file access strobe |
| tf_we | output | 1 | Task-file write |
| tf_addr | output | 3 | Task-file register address |
| tf_alt | output | 1 | Status read is the alternate (side-effect-free) read |
| tf_wdata | output | 16 | Task-file write data |
| tf_rdata | input | 16 | Task-file read data, valid in the strobe cycle |
| dev_ctl | output | 8 | Device-control register |
| soft_rst | output | 1 | Software-reset pulse |
| irq_eval | output | 1 | Interrupt re-evaluation pulse |

## Verification
The task-file strobes, address, alternate flag, write data and wake are due in the same cycle as the host access. The bench drives inputs just after a falling edge and compares these outputs one time unit later, before the rising edge. Host read data, the device-control value and both pulses are due on the next rising edge, so the bench compares them at the following falling edge. The behavioural model in the bench advances its cycle flag and byte latch at that same rising edge, which keeps its pairing of byte accesses in step with the design.

// File: rtl/tfw_pkg.sv
package tfw_pkg;

  typedef enum logic [1:0] {
    MODE_MEM  = 2'd0,
    MODE_IO16 = 2'd1,
    MODE_PRI  = 2'd2,
    MODE_SEC  = 2'd3
  } tfw_mode_e;

  // Host-side register offsets handled specially.
  localparam logic [3:0] OFF_WORD    = 4'h0;
  localparam logic [3:0] OFF_BYTE    = 4'h8;
  localparam logic [3:0] OFF_ERRFEAT = 4'hD;
  localparam logic [3:0] OFF_ALTCTL  = 4'hE;
  localparam logic [3:0] OFF_DEVADDR = 4'hF;

  // Task-file side addresses.
  localparam logic [2:0] TF_DATA = 3'd0;
  localparam logic [2:0] TF_ERR  = 3'd1;
  localparam logic [2:0] TF_STAT = 3'd7;

  localparam int CTL_SRST_BIT = 2;

  // Join the second byte (upper half) with the stored first byte.
  function automatic logic [15:0] pack_word(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  // Synthesized device-address value.
  function automatic logic [7:0] dev_addr_byte(input logic [3:0] sel);
    return 8'hC2 | {2'b00, ~sel, 2'b00};
  endfunction

  function automatic logic ctl_wants_reset(input logic [7:0] v);
    return v[CTL_SRST_BIT];
  endfunction

endpackage

// File: rtl/tfw_window.sv
module tfw_window
  import tfw_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int MEM_SHIFT = 10
) (
  input  tfw_mode_e         mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [3:0]        off
);
  localparam int BLK_W = ADDR_W - 4;
  localparam int TAG_W = ADDR_W - MEM_SHIFT;
  localparam logic [BLK_W-1:0] PRI_LO = BLK_W'('h1F);
  localparam logic [BLK_W-1:0] PRI_HI = BLK_W'('h3F);
  localparam logic [BLK_W-1:0] SEC_LO = BLK_W'('h17);
  localparam logic [BLK_W-1:0] SEC_HI = BLK_W'('h37);
  localparam logic [TAG_W-1:0] MEM_TAG = TAG_W'(1);

  logic [BLK_W-1:0] blk;
  logic [TAG_W-1:0] tag;
  assign blk = addr[ADDR_W-1:4];
  assign tag = addr[ADDR_W-1:MEM_SHIFT];

  // Upper I/O block folds onto offsets 8..F.
  function automatic logic [3:0] fold_high(input logic [2:0] low);
    return {1'b1, low};
  endfunction

  always_comb begin
    hit = 1'b0;
    off = addr[3:0];
    case (mode)
      MODE_MEM:  hit = (tag == MEM_TAG);
      MODE_IO16: hit = 1'b1;
      MODE_PRI: begin
        if (blk == PRI_LO) begin
          hit = 1'b1;
        end else if (blk == PRI_HI) begin
          hit = 1'b1;
          off = fold_high(addr[2:0]);
        end
      end
      default: begin
        if (blk == SEC_LO) begin
          hit = 1'b1;
        end else if (blk == SEC_HI) begin
          hit = 1'b1;
          off = fold_high(addr[2:0]);
        end
      end
    endcase
  end
endmodule

// File: rtl/tfw_packer.sv
module tfw_packer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load_word,
  input  logic          load_low,
  input  logic [DW-1:0] rword,
  input  logic [7:0]    wbyte,
  output logic          cyc,
  output logic [DW-1:0] latch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc   <= 1'b0;
      latch <= '0;
    end else begin
      if (step)      cyc        <= ~cyc;
      if (load_word) latch      <= rword;
      if (load_low)  latch[7:0] <= wbyte;
    end
  end
endmodule

// File: rtl/tfw_route.sv
module tfw_route
  import tfw_pkg::*;
(
  input  logic        host_cs,
  input  logic        host_we,
  input  logic [15:0] host_wdata,
  input  logic        hit,
  input  logic [3:0]  off,
  input  logic        cyc,
  input  logic [15:0] latch,
  input  logic [15:0] tf_rdata,
  input  logic [3:0]  head_sel,
  input  logic        pwr_down,
  output logic        tf_cs,
  output logic        tf_we,
  output logic [2:0]  tf_addr,
  output logic        tf_alt,
  output logic [15:0] tf_wdata,
  output logic        wake,
  output logic        byte_step,
  output logic        load_word,
  output logic        load_low,
  output logic        ctl_wr,
  output logic [15:0] rd_value
);
  always_comb begin
    tf_cs     = 1'b0;
    tf_we     = 1'b0;
    tf_addr   = TF_DATA;
    tf_alt    = 1'b0;
    tf_wdata  = host_wdata;
    wake      = 1'b0;
    byte_step = 1'b0;
    load_word = 1'b0;
    load_low  = 1'b0;
    ctl_wr    = 1'b0;
    rd_value  = 16'h0000;
    if (host_cs && hit) begin
      case (off)
        OFF_WORD: begin
          tf_cs    = 1'b1;
          tf_we    = host_we;
          rd_value = tf_rdata;
        end
        OFF_BYTE: begin
          byte_step = 1'b1;
          if (host_we) begin
            if (cyc) begin
              tf_cs    = 1'b1;
              tf_we    = 1'b1;
              tf_wdata = pack_word(host_wdata[7:0], latch[7:0]);
            end else begin
              load_low = 1'b1;
            end
          end else if (cyc) begin
            rd_value = {8'h00, latch[15:8]};
          end else begin
            tf_cs     = 1'b1;
            load_word = 1'b1;
            rd_value  = {8'h00, tf_rdata[7:0]};
          end
        end
        OFF_ERRFEAT: begin
          tf_cs    = 1'b1;
          tf_we    = host_we;
          tf_addr  = TF_ERR;
          rd_value = tf_rdata;
        end
        OFF_ALTCTL: begin
          if (host_we) begin
            ctl_wr = 1'b1;
          end else begin
            tf_cs    = 1'b1;
            tf_addr  = TF_STAT;
            tf_alt   = 1'b1;
            rd_value = tf_rdata;
          end
        end
        OFF_DEVADDR: begin
          if (!host_we) rd_value = {8'h00, dev_addr_byte(head_sel)};
        end
        default: begin
          tf_cs    = 1'b1;
          tf_we    = host_we;
          tf_addr  = off[2:0];
          rd_value = tf_rdata;
          wake     = host_we && pwr_down;
        end
      endcase
    end
  end
endmodule

// File: rtl/tfw_decoder_top.sv
module tfw_decoder_top
  import tfw_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int MEM_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic [3:0]        head_sel,
  input  logic              pwr_down,
  output logic              wake,
  output logic              tf_cs,
  output logic              tf_we,
  output logic [2:0]        tf_addr,
  output logic              tf_alt,
  output logic [15:0]       tf_wdata,
  input  logic [15:0]       tf_rdata,
  output logic [7:0]        dev_ctl,
  output logic              soft_rst,
  output logic              irq_eval
);
  // Named internal events, visible to the bound checker.
  logic        win_hit;
  logic [3:0]  win_off;
  logic        pack_cyc;
  logic [15:0] pack_latch;
  logic        byte_step;
  logic        load_word;
  logic        load_low;
  logic        ctl_wr;
  logic        rd_fire;
  logic [15:0] rd_value;
  tfw_mode_e   mode_e;

  assign mode_e  = tfw_mode_e'(mode);
  assign rd_fire = host_cs && !host_we;

  tfw_window #(.ADDR_W(ADDR_W), .MEM_SHIFT(MEM_SHIFT)) u_win (
    .mode (mode_e),
    .addr (host_addr),
    .hit  (win_hit),
    .off  (win_off)
  );

  tfw_packer #(.DW(16)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (byte_step),
    .load_word (load_word),
    .load_low  (load_low),
    .rword     (tf_rdata),
    .wbyte     (host_wdata[7:0]),
    .cyc       (pack_cyc),
    .latch     (pack_latch)
  );

  tfw_route u_route (
    .host_cs    (host_cs),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .hit        (win_hit),
    .off        (win_off),
    .cyc        (pack_cyc),
    .latch      (pack_latch),
    .tf_rdata   (tf_rdata),
    .head_sel   (head_sel),
    .pwr_down   (pwr_down),
    .tf_cs      (tf_cs),
    .tf_we      (tf_we),
    .tf_addr    (tf_addr),
    .tf_alt     (tf_alt),
    .tf_wdata   (tf_wdata),
    .wake       (wake),
    .byte_step  (byte_step),
    .load_word  (load_word),
    .load_low   (load_low),
    .ctl_wr     (ctl_wr),
    .rd_value   (rd_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= 16'h0000;
      dev_ctl    <= 8'h00;
      soft_rst   <= 1'b0;
      irq_eval   <= 1'b0;
    end else begin
      if (rd_fire) host_rdata <= rd_value;
      if (ctl_wr)  dev_ctl    <= host_wdata[7:0];
      soft_rst <= ctl_wr && ctl_wants_reset(host_wdata[7:0]);
      irq_eval <= ctl_wr;
    end
  end
endmodule

// File: rtl/tfw_checks.sv
module tfw_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        host_cs,
  input logic        host_we,
  input logic        win_hit,
  input logic        byte_step,
  input logic        pack_cyc,
  input logic        tf_cs,
  input logic        tf_we,
  input logic [2:0]  tf_addr,
  input logic        tf_alt,
  input logic        wake,
  input logic        pwr_down,
  input logic        soft_rst,
  input logic        irq_eval,
  input logic        ctl_srst_bit,
  input logic [15:0] host_rdata
);
  assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && !win_hit) |-> (!tf_cs && !wake));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_cs |-> (!tf_cs && !wake));

  assert_flag_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_step |=> (pack_cyc != $past(pack_cyc)));

  assert_pair_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_step && tf_cs && tf_we) |-> pack_cyc);

  assert_pulse_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (irq_eval && ctl_srst_bit));

  assert_alt_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tf_alt |-> (tf_cs && !tf_we && tf_addr == 3'd7));

  assert_wake_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (tf_cs && tf_we && pwr_down));

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_cs && !host_we) |=> $stable(host_rdata));
endmodule

bind tfw_decoder_top tfw_checks u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_cs      (host_cs),
  .host_we      (host_we),
  .win_hit      (win_hit),
  .byte_step    (byte_step),
  .pack_cyc     (pack_cyc),
  .tf_cs        (tf_cs),
  .tf_we        (tf_we),
  .tf_addr      (tf_addr),
  .tf_alt       (tf_alt),
  .wake         (wake),
  .pwr_down     (pwr_down),
  .soft_rst     (soft_rst),
  .irq_eval     (irq_eval),
  .ctl_srst_bit (dev_ctl[2]),
  .host_rdata   (host_rdata)
);

// File: tb/tb_tfw_decoder_top.sv
module tb_tfw_decoder_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd1;
  logic          host_cs = 1'b0;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0]   host_wdata = '0;
  logic [15:0]   host_rdata;
  logic [3:0]    head_sel = 4'h0;
  logic          pwr_down = 1'b0;
  logic          wake;
  logic          tf_cs, tf_we, tf_alt;
  logic [2:0]    tf_addr;
  logic [15:0]   tf_wdata;
  logic [15:0]   tf_rdata = 16'h0000;
  logic [7:0]    dev_ctl;
  logic          soft_rst, irq_eval;

  int checks = 0;
  int errors = 0;

  // Reference model state.
  bit          m_cyc;
  logic [15:0] m_latch;
  logic [15:0] m_rdata;
  logic [7:0]  m_ctl;
  bit          m_srst, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tfw_decoder_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .head_sel(head_sel), .pwr_down(pwr_down), .wake(wake), .tf_cs(tf_cs),
    .tf_we(tf_we), .tf_addr(tf_addr), .tf_alt(tf_alt), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata), .dev_ctl(dev_ctl), .soft_rst(soft_rst), .irq_eval(irq_eval)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cyc = 0; m_latch = 16'h0; m_rdata = 16'h0; m_ctl = 8'h0; m_srst = 0; m_irq = 0;
  endtask

  task automatic check_regs(input string tag);
    chk(tag, "host_rdata", {16'h0, host_rdata}, {16'h0, m_rdata});
    chk(tag, "dev_ctl", {24'h0, dev_ctl}, {24'h0, m_ctl});
    chk(tag, "soft_rst", {31'h0, soft_rst}, {31'h0, m_srst});
    chk(tag, "irq_eval", {31'h0, irq_eval}, {31'h0, m_irq});
  endtask

  // One clock cycle: drive, compare same-cycle outputs, step the model, compare registers.
  task automatic acc(input string tag, input bit cs, input bit we, input int addr,
                     input logic [15:0] wd);
    bit hit; int off;
    bit e_cs, e_we, e_alt, e_wake; int e_addr; logic [15:0] e_wd, nrd;
    bit n_cyc; logic [15:0] n_latch; logic [7:0] n_ctl; bit n_srst, n_irq;
    host_cs = cs; host_we = we; host_addr = AW'(addr); host_wdata = wd;
    #1;
    hit = 0; off = addr % 16;
    case (mode)
      2'd0: hit = (addr / 1024) == 1;
      2'd1: hit = 1;
      2'd2: if (addr / 16 == 31) hit = 1;
            else if (addr / 16 == 63) begin hit = 1; off = 8 + addr % 8; end
      default: if (addr / 16 == 23) hit = 1;
               else if (addr / 16 == 55) begin hit = 1; off = 8 + addr % 8; end
    endcase
    e_cs = 0; e_we = 0; e_alt = 0; e_wake = 0; e_addr = 0; e_wd = wd; nrd = 16'h0;
    n_cyc = m_cyc; n_latch = m_latch; n_ctl = m_ctl; n_srst = 0; n_irq = 0;
    if (cs && hit) begin
      if (off == 0) begin
        e_cs = 1; e_we = we; nrd = tf_rdata;
      end else if (off == 8) begin
        n_cyc = !m_cyc;
        if (we) begin
          if (m_cyc) begin e_cs = 1; e_we = 1; e_wd = {wd[7:0], m_latch[7:0]}; end
          else n_latch[7:0] = wd[7:0];
        end else if (m_cyc) nrd = {8'h00, m_latch[15:8]};
        else begin e_cs = 1; n_latch = tf_rdata; nrd = {8'h00, tf_rdata[7:0]}; end
      end else if (off == 13) begin
        e_cs = 1; e_we = we; e_addr = 1; nrd = tf_rdata;
      end else if (off == 14) begin
        if (we) begin n_ctl = wd[7:0]; n_irq = 1; n_srst = wd[2]; end
        else begin e_cs = 1; e_addr = 7; e_alt = 1; nrd = tf_rdata; end
      end else if (off == 15) begin
        nrd = 16'(194 + 4 * (15 - int'(head_sel)));
      end else begin
        e_cs = 1; e_we = we; e_addr = off % 8; nrd = tf_rdata; e_wake = we && pwr_down;
      end
    end
    chk(tag, "tf_cs", {31'h0, tf_cs}, {31'h0, e_cs});
    chk(tag, "wake", {31'h0, wake}, {31'h0, e_wake});
    if (e_cs) begin
      chk(tag, "tf_we", {31'h0, tf_we}, {31'h0, e_we});
      chk(tag, "tf_addr", {29'h0, tf_addr}, 32'(e_addr));
      chk(tag, "tf_alt", {31'h0, tf_alt}, {31'h0, e_alt});
      if (e_we) chk(tag, "tf_wdata", {16'h0, tf_wdata}, {16'h0, e_wd});
    end
    @(posedge clk);
    m_cyc = n_cyc; m_latch = n_latch; m_ctl = n_ctl; m_srst = n_srst; m_irq = n_irq;
    if (cs && !we) m_rdata = nrd;
    @(negedge clk);
    check_regs(tag);
  endtask

  task automatic do_reset();
    host_cs = 0; rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
    chk("R13", "reset host_rdata", {16'h0, host_rdata}, 32'h0);
    chk("R10", "reset dev_ctl", {24'h0, dev_ctl}, 32'h0);
    chk("R10", "reset pulses", {30'h0, soft_rst, irq_eval}, 32'h0);
    chk("R4", "reset tf_cs idle", {31'h0, tf_cs}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();

    mode = 2'd1;
    tf_rdata = 16'hBEEF; acc("R5", 1, 0, 'h230, 16'h0);
    acc("R5", 1, 1, 'h000, 16'h5A5A);
    tf_rdata = 16'h3131; acc("R2", 1, 0, 'h7F3, 16'h0);
    tf_rdata = 16'h1234; acc("R6", 1, 0, 'h008, 16'h0);
    tf_rdata = 16'h9999; acc("R6", 1, 0, 'h008, 16'h0);
    acc("R7", 1, 1, 'h008, 16'h77AB);
    acc("R7", 1, 1, 'h018, 16'h66CD);
    acc("R4", 0, 0, 'h000, 16'h0);
    tf_rdata = 16'h7788; acc("R8", 1, 0, 'h008, 16'h0);
    acc("R8", 1, 1, 'h008, 16'h0011);
    tf_rdata = 16'h0004; acc("R9", 1, 0, 'h00D, 16'h0);
    acc("R9", 1, 1, 'h00D, 16'h0003);
    tf_rdata = 16'h0050; acc("R10", 1, 0, 'h00E, 16'h0);
    acc("R10", 1, 1, 'h00E, 16'h0004);
    acc("R10", 1, 1, 'h00E, 16'h0002);
    acc("R10", 0, 0, 'h000, 16'h0);
    head_sel = 4'h0; acc("R11", 1, 0, 'h00F, 16'h0);
    head_sel = 4'hA; acc("R11", 1, 0, 'h00F, 16'h0);
    acc("R11", 1, 1, 'h00F, 16'h1234);
    pwr_down = 1;
    acc("R12", 1, 1, 'h00B, 16'h00EE);
    acc("R12", 1, 0, 'h00B, 16'h0);
    acc("R12", 1, 1, 'h000, 16'h0101);
    acc("R12", 1, 1, 'h00E, 16'h0000);
    pwr_down = 0;
    acc("R12", 1, 1, 'h002, 16'h0042);

    mode = 2'd0;
    tf_rdata = 16'hA5A5; acc("R1", 1, 0, 'h405, 16'h0);
    acc("R1", 1, 0, 'h3F5, 16'h0);
    acc("R1", 1, 1, 'h20D, 16'h00FF);
    acc("R1", 1, 1, 'h7FD, 16'h0009);

    mode = 2'd2;
    tf_rdata = 16'h00D0; acc("R3", 1, 0, 'h1F7, 16'h0);
    acc("R3", 1, 0, 'h3F6, 16'h0);
    head_sel = 4'h3; acc("R3", 1, 0, 'h3F7, 16'h0);
    acc("R3", 1, 0, 'h177, 16'h0);
    acc("R3", 1, 1, 'h3F6, 16'h0004);
    mode = 2'd3;
    tf_rdata = 16'h0E0E; acc("R3", 1, 0, 'h171, 16'h0);
    acc("R3", 1, 0, 'h376, 16'h0);
    acc("R3", 1, 0, 'h1F1, 16'h0);

    mode = 2'd2;
    acc("R4", 1, 1, 'h1F8, 16'h0042);
    acc("R4", 1, 1, 'h222, 16'h0099);
    acc("R4", 1, 0, 'h100, 16'h0);
    acc("R4", 1, 1, 'h1F8, 16'h0024);

    mode = 2'd1;
    acc("R8", 1, 1, 'h008, 16'h0055);
    do_reset();
    tf_rdata = 16'h6677; acc("R8", 1, 0, 'h008, 16'h0);
    acc("R8", 1, 0, 'h008, 16'h0);
    acc("R13", 0, 0, 'h000, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule